// File: doc/BRIEF.md
# Fractional-Nanosecond Time-of-Day Counter

This block keeps a free-running time-of-day value for precision time protocol use. The value is held as whole nanoseconds plus a binary fraction of a nanosecond. While counting is switched on, the block adds a programmable increment on every core clock cycle. The increment is a 32.32 fixed-point count of nanoseconds, so the counter can track a core clock whose period is not a whole number of nanoseconds. For a core clock of F hertz, the nominal increment is (10^9 << 32) / F.

Software uses a plain 64-bit register port with valid, write, address and data signals. Through it, software switches counting on and off, programs the increment, and reads or loads the two time words. Read data is registered and comes back one clock after the request.

Top module: `tod_counter`

## Requirements
- R1: After reset, the time value is zero, the enable bit is clear and the increment is zero, so a read of any mapped register returns 0.
- R2: While enabled, on every clock the 96-bit time value (64 bits of nanoseconds above 32 bits of fraction) grows by the increment. The increment is zero-extended, with its upper 32 bits as whole nanoseconds and its lower 32 bits as fraction.
- R3: While the enable bit is clear, the time value holds and is kept for later reads and resumed counting.
- R4: A read at offset 0xF10 returns the upper 64 bits of the time value (nanoseconds). A read at offset 0xF08 returns the lower 32 bits (fraction) in bits 31:0, with bits 63:32 as zero.
- R5: A write to the increment register at offset 0xF18 stores all 64 bits and reads back unchanged. The addition in the write cycle still uses the old increment, and the new one applies from the next cycle. The accumulated fraction is not lost.
- R6: The configuration register sits at offset 0xF00 and bit 0 is the enable. Other written bits are dropped, and a read returns only the enable in bit 0, with the other bits zero.
- R7: A write to 0xF10 loads the nanosecond part from all 64 data bits. A write to 0xF08 loads the fraction from data bits 31:0 and ignores bits 63:32. The other part is kept, and in that cycle the load replaces the addition.
- R8: A read of any offset other than 0xF00, 0xF08, 0xF10 or 0xF18 returns 0, and a write to such an offset changes no register.
- R9: A read request updates the read data at the next clock edge with the register value from before that edge. The read data then holds until the next read request.
- R10: Carries pass from the fraction into the nanoseconds. The 96-bit value wraps to zero past its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access request this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Registered read data |

## Verification
Every register effect is due one clock edge after the request:
- A write to configuration, increment or a time word shows in the state after the edge that takes the request.
- Read data appears after the edge that takes the read.
- A switched-on counter adds once per edge, including the edge that takes the disabling write.

The bench drives inputs on the falling edge. A behavioural model steps on the same rising edge as the design, and the read data is compared on the following falling edge. Directed sequences count edges exactly, so each expected time value is a whole number of additions worked out by hand.

// File: rtl/tod_pkg.sv
package tod_pkg;

  localparam logic [11:0] TOD_OFS_CFG  = 12'hF00;
  localparam logic [11:0] TOD_OFS_FRAC = 12'hF08;
  localparam logic [11:0] TOD_OFS_NS   = 12'hF10;
  localparam logic [11:0] TOD_OFS_INC  = 12'hF18;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_CFG  = 3'd1,
    SEL_FRAC = 3'd2,
    SEL_NS   = 3'd3,
    SEL_INC  = 3'd4
  } tod_sel_e;

endpackage

// File: rtl/tod_regdec.sv
module tod_regdec #(
  parameter int          ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] OFS_CFG  = 12'hF00,
  parameter logic [ADDR_W-1:0] OFS_FRAC = 12'hF08,
  parameter logic [ADDR_W-1:0] OFS_NS   = 12'hF10,
  parameter logic [ADDR_W-1:0] OFS_INC  = 12'hF18
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  output tod_pkg::tod_sel_e sel,
  output logic              rd_fire,
  output logic              wr_cfg,
  output logic              wr_frac,
  output logic              wr_ns,
  output logic              wr_inc
);
  import tod_pkg::*;

  logic wr_fire;

  always_comb begin
    if (addr == OFS_CFG)       sel = SEL_CFG;
    else if (addr == OFS_FRAC) sel = SEL_FRAC;
    else if (addr == OFS_NS)   sel = SEL_NS;
    else if (addr == OFS_INC)  sel = SEL_INC;
    else                       sel = SEL_NONE;
  end

  assign wr_fire = valid & write;
  assign rd_fire = valid & ~write;
  assign wr_cfg  = wr_fire & (sel == SEL_CFG);
  assign wr_frac = wr_fire & (sel == SEL_FRAC);
  assign wr_ns   = wr_fire & (sel == SEL_NS);
  assign wr_inc  = wr_fire & (sel == SEL_INC);

endmodule

// File: rtl/tod_ctlregs.sv
module tod_ctlregs #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cfg,
  input  logic              cfg_en_bit,
  input  logic              wr_inc,
  input  logic [DATA_W-1:0] inc_data,
  output logic              en_q,
  output logic [DATA_W-1:0] inc_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      inc_q <= '0;
    end else begin
      if (wr_cfg) en_q  <= cfg_en_bit;
      if (wr_inc) inc_q <= inc_data;
    end
  end

endmodule

// File: rtl/tod_accum.sv
module tod_accum #(
  parameter int DATA_W = 64,
  parameter int FRAC_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [DATA_W-1:0]        inc,
  input  logic                     ld_ns,
  input  logic                     ld_frac,
  input  logic [DATA_W-1:0]        ld_data,
  output logic [DATA_W+FRAC_W-1:0] acc_q
);
  localparam int ACC_W = DATA_W + FRAC_W;

  // Time plus zero-extended fixed-point increment; wraps modulo 2^ACC_W.
  function automatic logic [ACC_W-1:0] time_step(
    input logic [ACC_W-1:0]  t,
    input logic [DATA_W-1:0] d
  );
    return t + {{(ACC_W-DATA_W){1'b0}}, d};
  endfunction

  // Replace the whole-nanosecond part, keep the fraction.
  function automatic logic [ACC_W-1:0] put_ns(
    input logic [ACC_W-1:0]  t,
    input logic [DATA_W-1:0] d
  );
    return {d, t[FRAC_W-1:0]};
  endfunction

  // Replace the fraction, keep the nanoseconds.
  function automatic logic [ACC_W-1:0] put_frac(
    input logic [ACC_W-1:0]  t,
    input logic [FRAC_W-1:0] f
  );
    return {t[ACC_W-1:FRAC_W], f};
  endfunction

  logic [ACC_W-1:0] acc_d;

  always_comb begin
    if (ld_ns)        acc_d = put_ns(acc_q, ld_data);
    else if (ld_frac) acc_d = put_frac(acc_q, ld_data[FRAC_W-1:0]);
    else if (en)      acc_d = time_step(acc_q, inc);
    else              acc_d = acc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

endmodule

// File: rtl/tod_rdport.sv
module tod_rdport #(
  parameter int DATA_W = 64,
  parameter int FRAC_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_fire,
  input  tod_pkg::tod_sel_e        sel,
  input  logic                     en,
  input  logic [DATA_W-1:0]        inc,
  input  logic [DATA_W+FRAC_W-1:0] acc,
  output logic [DATA_W-1:0]        rdata
);
  import tod_pkg::*;
  localparam int ACC_W = DATA_W + FRAC_W;

  logic [DATA_W-1:0] frac_word;
  logic [DATA_W-1:0] mux_d;

  generate
    if (FRAC_W < DATA_W) begin : g_frac_pad
      assign frac_word = {{(DATA_W-FRAC_W){1'b0}}, acc[FRAC_W-1:0]};
    end else begin : g_frac_full
      assign frac_word = acc[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    case (sel)
      SEL_CFG:  mux_d = {{(DATA_W-1){1'b0}}, en};
      SEL_FRAC: mux_d = frac_word;
      SEL_NS:   mux_d = acc[ACC_W-1:FRAC_W];
      SEL_INC:  mux_d = inc;
      default:  mux_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rdata <= '0;
    else if (rd_fire) rdata <= mux_d;
  end

endmodule

// File: rtl/tod_counter.sv
module tod_counter #(
  parameter int DATA_W = 64,
  parameter int FRAC_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] OFS_CFG  = tod_pkg::TOD_OFS_CFG,
  parameter logic [ADDR_W-1:0] OFS_FRAC = tod_pkg::TOD_OFS_FRAC,
  parameter logic [ADDR_W-1:0] OFS_NS   = tod_pkg::TOD_OFS_NS,
  parameter logic [ADDR_W-1:0] OFS_INC  = tod_pkg::TOD_OFS_INC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int ACC_W = DATA_W + FRAC_W;

  tod_pkg::tod_sel_e sel;
  logic              rd_fire;
  logic              wr_cfg;
  logic              wr_frac;
  logic              wr_ns;
  logic              wr_inc;
  logic              en_q;
  logic [DATA_W-1:0] inc_q;
  logic [ACC_W-1:0]  acc_q;
  logic              ld_any;

  assign ld_any = wr_ns | wr_frac;

  tod_regdec #(
    .ADDR_W(ADDR_W), .OFS_CFG(OFS_CFG), .OFS_FRAC(OFS_FRAC),
    .OFS_NS(OFS_NS), .OFS_INC(OFS_INC)
  ) u_dec (
    .valid(reg_valid), .write(reg_write), .addr(reg_addr),
    .sel(sel), .rd_fire(rd_fire), .wr_cfg(wr_cfg),
    .wr_frac(wr_frac), .wr_ns(wr_ns), .wr_inc(wr_inc)
  );

  tod_ctlregs #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_cfg(wr_cfg), .cfg_en_bit(reg_wdata[0]),
    .wr_inc(wr_inc), .inc_data(reg_wdata), .en_q(en_q), .inc_q(inc_q)
  );

  tod_accum #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .en(en_q), .inc(inc_q),
    .ld_ns(wr_ns), .ld_frac(wr_frac), .ld_data(reg_wdata), .acc_q(acc_q)
  );

  tod_rdport #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .sel(sel),
    .en(en_q), .inc(inc_q), .acc(acc_q), .rdata(reg_rdata)
  );

endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
  parameter int DATA_W = 64,
  parameter int FRAC_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] OFS_CFG  = 12'hF00,
  parameter logic [ADDR_W-1:0] OFS_FRAC = 12'hF08,
  parameter logic [ADDR_W-1:0] OFS_NS   = 12'hF10,
  parameter logic [ADDR_W-1:0] OFS_INC  = 12'hF18
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     reg_valid,
  input logic                     reg_write,
  input logic [ADDR_W-1:0]        reg_addr,
  input logic [DATA_W-1:0]        reg_wdata,
  input logic [DATA_W-1:0]        reg_rdata,
  input logic                     en_q,
  input logic [DATA_W-1:0]        inc_q,
  input logic [DATA_W+FRAC_W-1:0] acc_q,
  input logic                     ld_any
);
  localparam int ACC_W = DATA_W + FRAC_W;

  logic is_rd, is_wr, mapped;
  assign is_rd  = reg_valid & ~reg_write;
  assign is_wr  = reg_valid & reg_write;
  assign mapped = (reg_addr == OFS_CFG) | (reg_addr == OFS_FRAC) |
                  (reg_addr == OFS_NS)  | (reg_addr == OFS_INC);

  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !ld_any) |=> acc_q == ($past(acc_q) + {{FRAC_W{1'b0}}, $past(inc_q)})); // R2
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !ld_any) |=> $stable(acc_q)); // R3
  AST_FRAC_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && reg_addr == OFS_FRAC) |=> reg_rdata == {{(DATA_W-FRAC_W){1'b0}}, $past(acc_q[FRAC_W-1:0])}); // R4
  AST_NS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && reg_addr == OFS_NS) |=> reg_rdata == $past(acc_q[ACC_W-1:FRAC_W])); // R4
  AST_INC_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && reg_addr == OFS_INC) |=> inc_q == $past(reg_wdata)); // R5
  AST_CFG_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && reg_addr == OFS_CFG) |=> reg_rdata == {{(DATA_W-1){1'b0}}, $past(en_q)}); // R6
  AST_NS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && reg_addr == OFS_NS) |=> acc_q[ACC_W-1:FRAC_W] == $past(reg_wdata)); // R7
  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && !mapped) |=> reg_rdata == '0); // R8
  AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && !mapped) |=> ($stable(inc_q) && $stable(en_q))); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !is_rd |=> $stable(reg_rdata)); // R9

endmodule

bind tod_counter tod_counter_chk #(
  .DATA_W(DATA_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W),
  .OFS_CFG(OFS_CFG), .OFS_FRAC(OFS_FRAC), .OFS_NS(OFS_NS), .OFS_INC(OFS_INC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .en_q(en_q), .inc_q(inc_q), .acc_q(acc_q), .ld_any(ld_any)
);

// File: tb/tod_counter_bench.sv
module tod_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0;
  logic        reg_write = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tod_counter u_tod_counter (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // Behavioural reference: one 96-bit time value, stepped per rising edge.
  logic [95:0] m_time, m_next;
  logic [63:0] m_inc, m_rdata;
  bit          m_on;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_time <= '0; m_inc <= '0; m_on <= 1'b0; m_rdata <= '0;
    end else begin
      m_next = m_on ? m_time + {32'd0, m_inc} : m_time;
      if (reg_valid && reg_write) begin
        if (reg_addr == 12'hF00) m_on <= reg_wdata[0];
        if (reg_addr == 12'hF18) m_inc <= reg_wdata;
        if (reg_addr == 12'hF10) m_next = {reg_wdata, m_time[31:0]};
        if (reg_addr == 12'hF08) m_next = {m_time[95:32], reg_wdata[31:0]};
      end
      if (reg_valid && !reg_write) begin
        if (reg_addr == 12'hF00)      m_rdata <= {63'd0, m_on};
        else if (reg_addr == 12'hF08) m_rdata <= {32'd0, m_time[31:0]};
        else if (reg_addr == 12'hF10) m_rdata <= m_time[95:32];
        else if (reg_addr == 12'hF18) m_rdata <= m_inc;
        else                          m_rdata <= '0;
      end
      m_time <= m_next;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (reg_rdata !== m_rdata) begin
        errors++;
        $display("FAIL R9 per-cycle model: actual %h expected %h", reg_rdata, m_rdata);
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_valid = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(12'hF00, v); chk("R1 cfg", v, 64'd0);
    rd(12'hF08, v); chk("R1 frac", v, 64'd0);
    rd(12'hF10, v); chk("R1 ns", v, 64'd0);
    rd(12'hF18, v); chk("R1 inc", v, 64'd0);

    // R6 only bit 0 kept
    wr(12'hF00, 64'hFFFF_FFFF_FFFF_FFFE);
    rd(12'hF00, v); chk("R6 bit0 clear", v, 64'd0);
    wr(12'hF00, 64'h8000_0000_0000_00F3);
    rd(12'hF00, v); chk("R6 bit0 set", v, 64'd1);
    wr(12'hF00, 64'd0);

    // R2 ten additions of 8 ns, then R3 hold
    wr(12'hF18, 64'h0000_0008_0000_0000);
    rd(12'hF18, v); chk("R5 inc readback", v, 64'h0000_0008_0000_0000);
    wr(12'hF00, 64'd1); idle(9); wr(12'hF00, 64'd0);
    rd(12'hF10, v); chk("R2 ns after 10 steps", v, 64'd80);
    rd(12'hF08, v); chk("R2 frac after 10 steps", v, 64'd0);
    idle(5);
    rd(12'hF10, v); chk("R3 ns held", v, 64'd80);

    // R10 carry: three steps of 1.5 ns from zero
    wr(12'hF10, 64'd0); wr(12'hF08, 64'd0);
    wr(12'hF18, 64'h0000_0001_8000_0000);
    wr(12'hF00, 64'd1); idle(2); wr(12'hF00, 64'd0);
    rd(12'hF10, v); chk("R10 carry ns", v, 64'd4);
    rd(12'hF08, v); chk("R4 frac word", v, 64'h0000_0000_8000_0000);

    // R5 increment change mid-run: 2 x 1 ns then 2 x 3 ns
    wr(12'hF10, 64'd0); wr(12'hF08, 64'd0);
    wr(12'hF18, 64'h0000_0001_0000_0000);
    wr(12'hF00, 64'd1); idle(1);
    wr(12'hF18, 64'h0000_0003_0000_0000); idle(1);
    wr(12'hF00, 64'd0);
    rd(12'hF10, v); chk("R5 new inc from next step", v, 64'd8);

    // R5 fraction kept across increment write
    wr(12'hF10, 64'd0); wr(12'hF08, 64'h0000_0000_C000_0000);
    wr(12'hF18, 64'h0000_0000_4000_0000);
    wr(12'hF00, 64'd1); wr(12'hF00, 64'd0);
    rd(12'hF10, v); chk("R5 fraction carry kept", v, 64'd1);
    rd(12'hF08, v); chk("R5 fraction zero", v, 64'd0);

    // R7 load replaces the addition
    wr(12'hF18, 64'h0000_0001_0000_0000);
    wr(12'hF00, 64'd1); wr(12'hF10, 64'd1000); wr(12'hF00, 64'd0);
    rd(12'hF10, v); chk("R7 ns load then one step", v, 64'd1001);
    wr(12'hF08, 64'hFFFF_FFFF_1234_5678);
    rd(12'hF08, v); chk("R7 frac low bits only", v, 64'h0000_0000_1234_5678);
    rd(12'hF10, v); chk("R7 ns kept on frac load", v, 64'd1001);

    // R8 unmapped offsets
    wr(12'hF20, 64'hDEAD_BEEF_DEAD_BEEF);
    wr(12'hF04, 64'h1);
    wr(12'h000, 64'h5555_5555_5555_5555);
    rd(12'hF20, v); chk("R8 unmapped read", v, 64'd0);
    rd(12'hF1C, v); chk("R8 near offset read", v, 64'd0);
    rd(12'hF00, v); chk("R8 cfg untouched", v, 64'd0);
    rd(12'hF18, v); chk("R8 inc untouched", v, 64'h0000_0001_0000_0000);
    rd(12'hF10, v); chk("R8 ns untouched", v, 64'd1001);

    // R9 read data holds between reads
    idle(4);
    chk("R9 rdata held", reg_rdata, 64'd1001);

    // R10 wrap of the full value
    wr(12'hF10, 64'hFFFF_FFFF_FFFF_FFFF); wr(12'hF08, 64'hFFFF_FFFF);
    wr(12'hF18, 64'd1);
    wr(12'hF00, 64'd1); wr(12'hF00, 64'd0);
    rd(12'hF10, v); chk("R10 wrap ns", v, 64'd0);
    rd(12'hF08, v); chk("R10 wrap frac", v, 64'd0);

    idle(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule